// File: doc/BRIEF.md
# Single-Wire Byte Master

This block is a memory-mapped master for a one-wire, byte-oriented slave bus. Software loads a byte into a transmit register, then writes the control register with a launch bit. Two qualifier bits in the same write select the operation. The block can shift the byte out to the slave, collect a byte that the slave drives back, or hold the line low for a break (reset) pulse. The line is open-drain: the block only ever pulls it low, through `line_oe_o`, and it watches the wire on `line_i`.

Every operation ends by clearing the launch bit and setting one flag in a sticky event register. Reading that register returns the flags and clears them. A level interrupt follows the pending flags, gated by an enable bit. A soft reset, a reset-done status bit and a fixed revision byte complete the register set.

All bus timings are parameters counted in system-clock cycles. A bit is encoded by how long the line is held low at the start of its cell: a short low is a 1 and a long low is a 0. Bits go out and come in least significant first.

Top module: `sw_bus_master`

## Requirements
- R1: After `rst_ni` is released, the control, event, receive and transmit registers read 0x00, and `irq_o` and `line_oe_o` are low.
- R2: Register offsets are as follows. 0x00 is revision, reading {REV_MAJOR, REV_MINOR} as nibbles 7:4 and 3:0. 0x04 is transmit data, which can be read back. 0x08 is receive data, read-only. 0x0C is control. 0x10 is events. 0x14 is system config. 0x18 is system status. Any other offset reads 0x00.
- R3: Control bits are: 6 interrupt enable, 5 clock enable, 4 GO, 2 INIT, 1 DIR, 0 mode. Writing GO=1 with INIT=0 and DIR=0 sends the transmit byte LSB first. Each cell is CELL_CYC cycles, with `line_oe_o` high for the first ONE_LOW_CYC cycles for a 1 or ZERO_LOW_CYC cycles for a 0. Exactly 8*CELL_CYC cycles after the launching write edge, GO reads 0 and event bit 2 (sent) is set.
- R4: Writing GO=1 with INIT=0 and DIR=1 collects one byte, LSB first. Each slave bit cell begins with a falling edge, and the line level is taken SAMPLE_CYC cycles after the edge is seen. High means 1. When the byte is complete, it appears in receive data, event bit 1 (received) is set, GO clears and DIR is kept. The line is never driven during a receive.
- R5: During a receive, if no falling edge is seen within RX_WAIT_CYC cycles of waiting, the operation ends exactly RX_WAIT_CYC cycles after the wait began. Event bit 0 (timeout) is set, bit 1 is not set, and GO clears.
- R6: Writing GO=1 with INIT=1, whatever the value of DIR, issues a break. `line_oe_o` is held high for BRK_LOW_CYC cycles and then released for BRK_REC_CYC cycles. At that point event bit 0 is set and both INIT and GO read 0.
- R7: A read of the event register returns the flags and clears them. If a flag is raised in the same cycle as the read, the new flag survives.
- R8: `irq_o` is high exactly when control bit 6 is set and at least one event flag is pending.
- R9: While an operation is in progress, control writes to bits 4:1 are ignored. Bits 6, 5 and 0 still update.
- R10: Writing 1 to system-config bit 1 aborts any operation, releases the line, and clears all registers, including auto-idle (system-config bit 0). System-status bit 0 then reads 0 for RST_CYC cycles before it returns to 1. Register writes in that window are ignored. System-config bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers clear-on-read) |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| line_i | input | 1 | Sensed level of the bus wire |
| line_oe_o | output | 1 | 1 pulls the bus wire low |
| irq_o | output | 1 | Level interrupt |

## Verification
A write takes effect at the rising edge on which its strobe is sampled, and read data follows the address in the same cycle. A transmit completes 8*CELL_CYC edges after the launch edge. A break completes BRK_LOW_CYC+BRK_REC_CYC edges after it. A silent receive times out after RX_WAIT_CYC edges. Reset-done returns RST_CYC edges after the soft-reset write. The bench counts falling edges from the launching write and samples the drive pattern and GO on the last cycle before each deadline and on the first cycle after it. The receive path runs through the input synchronizer, so its result is checked only once GO has cleared, with an upper bound on the wait. The set-beats-clear case is timed so that the event read lands on the completion edge of a transmit.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int OFF_REV  = 'h00;
  localparam int OFF_TX   = 'h04;
  localparam int OFF_RX   = 'h08;
  localparam int OFF_CTRL = 'h0C;
  localparam int OFF_EVT  = 'h10;
  localparam int OFF_CFG  = 'h14;
  localparam int OFF_STAT = 'h18;

  localparam int CTL_IE   = 6;
  localparam int CTL_CLK  = 5;
  localparam int CTL_GO   = 4;
  localparam int CTL_INIT = 2;
  localparam int CTL_DIR  = 1;
  localparam int CTL_MODE = 0;

  localparam int EVT_TX  = 2;
  localparam int EVT_RX  = 1;
  localparam int EVT_TMO = 0;

  localparam int CFG_SRST  = 1;
  localparam int CFG_AIDLE = 0;

  typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} swm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX, ST_RX_WAIT, ST_RX_SAMP, ST_BRK_LOW, ST_BRK_REC
  } swm_state_e;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b1;
        else         q <= d_i;
      assign q_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swm_engine.sv
module swm_engine
  import swm_pkg::*;
#(
  parameter int CELL_CYC     = 40,
  parameter int ONE_LOW_CYC  = 8,
  parameter int ZERO_LOW_CYC = 28,
  parameter int SAMPLE_CYC   = 18,
  parameter int RX_WAIT_CYC  = 100,
  parameter int BRK_LOW_CYC  = 60,
  parameter int BRK_REC_CYC  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  swm_op_e    op_i,
  input  logic [7:0] tx_byte_i,
  input  logic       abort_i,
  input  logic       line_s_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] evt_o,
  output logic [7:0] rx_byte_o,
  output logic       line_oe_o
);
  localparam int M1    = (CELL_CYC > RX_WAIT_CYC) ? CELL_CYC : RX_WAIT_CYC;
  localparam int M2    = (BRK_LOW_CYC > BRK_REC_CYC) ? BRK_LOW_CYC : BRK_REC_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] CELL_END = CNT_W'(CELL_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(RX_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] SAMP_END = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(BRK_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] REC_END  = CNT_W'(BRK_REC_CYC - 1);
  localparam logic [CNT_W-1:0] ONE_LEN  = CNT_W'(ONE_LOW_CYC);
  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(ZERO_LOW_CYC);

  swm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       sh_q;
  logic             prev_q;
  logic             fall;
  logic             last_bit;

  assign fall      = prev_q & ~line_s_i;
  assign last_bit  = (idx_q == 3'd7);
  assign busy_o    = (state_q != ST_IDLE);
  assign rx_byte_o = {line_s_i, sh_q[7:1]};

  always_comb begin
    line_oe_o = 1'b0;
    unique case (state_q)
      ST_TX:      line_oe_o = (cnt_q < (sh_q[0] ? ONE_LEN : ZERO_LEN));
      ST_BRK_LOW: line_oe_o = 1'b1;
      default:    line_oe_o = 1'b0;
    endcase
  end

  always_comb begin
    evt_o = 3'b000;
    unique case (state_q)
      ST_TX:      if (cnt_q == CELL_END && last_bit) evt_o[EVT_TX]  = 1'b1;
      ST_RX_WAIT: if (!fall && cnt_q == WAIT_END)    evt_o[EVT_TMO] = 1'b1;
      ST_RX_SAMP: if (cnt_q == SAMP_END && last_bit) evt_o[EVT_RX]  = 1'b1;
      ST_BRK_REC: if (cnt_q == REC_END)              evt_o[EVT_TMO] = 1'b1;
      default:    evt_o = 3'b000;
    endcase
    if (abort_i) evt_o = 3'b000;
  end
  assign done_o = |evt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
    end else begin
      prev_q <= line_s_i;
      if (abort_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= (op_i == OP_TX) ? tx_byte_i : 8'h00;
            unique case (op_i)
              OP_RX:   state_q <= ST_RX_WAIT;
              OP_BRK:  state_q <= ST_BRK_LOW;
              default: state_q <= ST_TX;
            endcase
          end
          ST_TX: begin
            if (cnt_q == CELL_END) begin
              cnt_q <= '0;
              if (last_bit) state_q <= ST_IDLE;
              else begin
                idx_q <= idx_q + 3'd1;
                sh_q  <= {1'b0, sh_q[7:1]};
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_RX_WAIT: begin
            if (fall) begin
              state_q <= ST_RX_SAMP;
              cnt_q   <= '0;
            end else if (cnt_q == WAIT_END) state_q <= ST_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
          ST_RX_SAMP: begin
            if (cnt_q == SAMP_END) begin
              sh_q  <= {line_s_i, sh_q[7:1]};
              cnt_q <= '0;
              if (last_bit) state_q <= ST_IDLE;
              else begin
                idx_q   <= idx_q + 3'd1;
                state_q <= ST_RX_WAIT;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_BRK_LOW: begin
            if (cnt_q == LOW_END) begin
              cnt_q   <= '0;
              state_q <= ST_BRK_REC;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_BRK_REC: begin
            if (cnt_q == REC_END) state_q <= ST_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot(evt_o)) else $error("one event per completion"); // R5
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o) else $error("engine idle after completion"); // R3
  AST_ABORT_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !line_oe_o)) else $error("abort releases line"); // R10
endmodule

// File: rtl/swm_regs.sv
module swm_regs
  import swm_pkg::*;
#(
  parameter int         ADDR_W    = 5,
  parameter logic [3:0] REV_MAJOR = 4'h1,
  parameter logic [3:0] REV_MINOR = 4'h2,
  parameter int         RST_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [2:0]        evt_i,
  input  logic [7:0]        rx_byte_i,
  output logic              start_o,
  output swm_op_e           op_o,
  output logic [7:0]        tx_byte_o,
  output logic              abort_o,
  output logic              go_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [7:0]      tx_q, rx_q;
  logic            ie_q, clken_q, go_q, init_q, dir_q, mode_q, aidle_q;
  logic [2:0]      evt_q;
  logic [RC_W-1:0] rcnt_q;
  logic            in_rst, wr_ok, rd_clr;
  logic            sel_rev, sel_tx, sel_rx, sel_ctrl, sel_evt, sel_cfg, sel_stat;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata_i[7], wdata_i[3]};

  assign sel_rev  = (addr_i == ADDR_W'(OFF_REV));
  assign sel_tx   = (addr_i == ADDR_W'(OFF_TX));
  assign sel_rx   = (addr_i == ADDR_W'(OFF_RX));
  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_evt  = (addr_i == ADDR_W'(OFF_EVT));
  assign sel_cfg  = (addr_i == ADDR_W'(OFF_CFG));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));

  assign in_rst  = (rcnt_q != '0);
  assign wr_ok   = wr_en_i & ~in_rst;
  assign rd_clr  = rd_en_i & sel_evt;
  assign abort_o = wr_ok & sel_cfg & wdata_i[CFG_SRST];
  assign start_o = wr_ok & sel_ctrl & wdata_i[CTL_GO] & ~busy_i;
  assign op_o    = wdata_i[CTL_INIT] ? OP_BRK : (wdata_i[CTL_DIR] ? OP_RX : OP_TX);
  assign tx_byte_o = tx_q;
  assign go_o    = go_q;
  assign irq_o   = ie_q & (|evt_q);

  always_comb begin
    rdata_o = 8'h00;
    if (sel_rev)  rdata_o = {REV_MAJOR, REV_MINOR};
    if (sel_tx)   rdata_o = tx_q;
    if (sel_rx)   rdata_o = rx_q;
    if (sel_ctrl) rdata_o = {1'b0, ie_q, clken_q, go_q, 1'b0, init_q, dir_q, mode_q};
    if (sel_evt)  rdata_o = {5'b0, evt_q};
    if (sel_cfg)  rdata_o = {7'b0, aidle_q};
    if (sel_stat) rdata_o = {7'b0, ~in_rst};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; evt_q <= '0;
      ie_q <= 1'b0; clken_q <= 1'b0; go_q <= 1'b0;
      init_q <= 1'b0; dir_q <= 1'b0; mode_q <= 1'b0; aidle_q <= 1'b0;
      rcnt_q <= RC_W'(RST_CYC);
    end else if (abort_o) begin
      tx_q <= '0; rx_q <= '0; evt_q <= '0;
      ie_q <= 1'b0; clken_q <= 1'b0; go_q <= 1'b0;
      init_q <= 1'b0; dir_q <= 1'b0; mode_q <= 1'b0; aidle_q <= 1'b0;
      rcnt_q <= RC_W'(RST_CYC);
    end else begin
      if (in_rst) rcnt_q <= rcnt_q - RC_W'(1);
      if (wr_ok && sel_tx) tx_q <= wdata_i;
      if (wr_ok && sel_cfg) aidle_q <= wdata_i[CFG_AIDLE];
      if (done_i && evt_i[EVT_RX]) rx_q <= rx_byte_i;
      if (wr_ok && sel_ctrl) begin
        ie_q    <= wdata_i[CTL_IE];
        clken_q <= wdata_i[CTL_CLK];
        mode_q  <= wdata_i[CTL_MODE];
        if (!busy_i) begin
          go_q   <= wdata_i[CTL_GO];
          init_q <= wdata_i[CTL_INIT];
          dir_q  <= wdata_i[CTL_DIR];
        end
      end
      if (done_i) begin
        go_q   <= 1'b0;
        init_q <= 1'b0;
      end
      // a flag raised on the clearing read survives it
      evt_q <= (rd_clr ? 3'b000 : evt_q) | evt_i;
    end
  end

  AST_EVT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !done_i) |=> (evt_q == 3'b000)) else $error("read must clear events"); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q == 3'b000) |-> !irq_o) else $error("irq without event"); // R8
  AST_GO_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> go_q) else $error("GO dropped during operation"); // R9
  AST_SRST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> in_rst) else $error("reset-done must fall"); // R10
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
  import swm_pkg::*;
#(
  parameter int         ADDR_W       = 5,
  parameter logic [3:0] REV_MAJOR    = 4'h1,
  parameter logic [3:0] REV_MINOR    = 4'h2,
  parameter int         CELL_CYC     = 40,
  parameter int         ONE_LOW_CYC  = 8,
  parameter int         ZERO_LOW_CYC = 28,
  parameter int         SAMPLE_CYC   = 18,
  parameter int         RX_WAIT_CYC  = 100,
  parameter int         BRK_LOW_CYC  = 60,
  parameter int         BRK_REC_CYC  = 20,
  parameter int         RST_CYC      = 4,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              irq_o
);
  logic       line_s, busy, done, start, abort, go;
  logic [2:0] evt;
  logic [7:0] rx_byte, tx_byte;
  swm_op_e    op;

  swm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  swm_regs #(
    .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .RST_CYC(RST_CYC)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .busy_i(busy), .done_i(done), .evt_i(evt), .rx_byte_i(rx_byte),
    .start_o(start), .op_o(op), .tx_byte_o(tx_byte), .abort_o(abort), .go_o(go)
  );

  swm_engine #(
    .CELL_CYC(CELL_CYC), .ONE_LOW_CYC(ONE_LOW_CYC), .ZERO_LOW_CYC(ZERO_LOW_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .RX_WAIT_CYC(RX_WAIT_CYC),
    .BRK_LOW_CYC(BRK_LOW_CYC), .BRK_REC_CYC(BRK_REC_CYC)
  ) i_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .op_i(op), .tx_byte_i(tx_byte),
    .abort_i(abort), .line_s_i(line_s), .busy_o(busy), .done_o(done), .evt_o(evt),
    .rx_byte_o(rx_byte), .line_oe_o(line_oe_o)
  );

  AST_OE_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> go) else $error("line driven without GO"); // R6
  AST_DONE_CLEARS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !go) else $error("GO must self-clear"); // R3
endmodule

// File: tb/test_sw_bus_master.sv
module test_sw_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 40, ONE = 8, ZERO = 28, RXW = 100, BLOW = 60, BREC = 20, RSTC = 4;
  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTRL = 5'h0C,
                         A_EVT = 5'h10, A_CFG = 5'h14, A_STAT = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, slave_low = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic line, line_oe, irq;
  logic oe_seen;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  assign line = ~(line_oe | slave_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  sw_bus_master i_sw_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .line_i(line), .line_oe_o(line_oe), .irq_o(irq)
  );

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_reg(logic [4:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [7:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic wait_idle(int limit);
    logic [7:0] v;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); peek(A_CTRL, v);
      if (!v[4]) return;
    end
    check("R4 GO did not clear in time", 1, 0);
  endtask

  task automatic slave_send(logic [7:0] b, int gap);
    for (int i = 0; i < gap; i++) begin @(negedge clk); oe_seen |= line_oe; end
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < CELL; c++) begin
        slave_low = (c < (b[k] ? ONE : ZERO));
        @(negedge clk); oe_seen |= line_oe;
      end
    end
    slave_low = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(A_CTRL, v); check("R1 ctrl after reset", v, 0);
    peek(A_EVT, v);  check("R1 events after reset", v, 0);
    peek(A_RX, v);   check("R1 rx after reset", v, 0);
    peek(A_TX, v);   check("R1 tx after reset", v, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 line released after reset", line_oe, 0);
    repeat (RSTC + 2) @(negedge clk);
    peek(A_STAT, v); check("R10 reset-done after hw reset", v, 1);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    peek(A_REV, v); check("R2 revision", v, 8'h12);
    write_reg(A_TX, 8'h5A); peek(A_TX, v); check("R2 tx readback", v, 8'h5A);
    write_reg(A_RX, 8'hFF); peek(A_RX, v); check("R2 rx read-only", v, 8'h00);
    peek(5'h1C, v); check("R2 unmapped offset", v, 0);
  endtask

  task automatic t_tx(logic [7:0] b);
    logic [7:0] v;
    int errs[8];
    for (int k = 0; k < 8; k++) errs[k] = 0;
    read_reg(A_EVT, v);
    write_reg(A_TX, b);
    write_reg(A_CTRL, 8'h10);
    for (int i = 0; i < 8*CELL; i++) begin
      if (line_oe !== ((i % CELL) < (b[i/CELL] ? ONE : ZERO))) errs[i/CELL]++;
      if (i == 8*CELL-1) begin
        peek(A_CTRL, v); check("R3 GO held in last cycle", v[4], 1);
        addr = A_EVT; rd_en = 1'b1; #1 check("R7 no event before completion", rdata, 0);
      end
      @(negedge clk);
    end
    rd_en = 1'b0;
    for (int k = 0; k < 8; k++) check($sformatf("R3 cell shape bit %0d", k), errs[k], 0);
    peek(A_EVT, v);  check("R7 flag raised on clearing read survives", v, 8'h04);
    peek(A_CTRL, v); check("R3 GO cleared at 8 cells", v, 8'h00);
    check("R8 irq off while disabled", irq, 0);
    read_reg(A_EVT, v); check("R7 read returns flags", v, 8'h04);
    peek(A_EVT, v);     check("R7 read clears flags", v, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    write_reg(A_CTRL, 8'h14);
    wait_idle(BLOW + BREC + 5);
    check("R8 irq gated by enable", irq, 0);
    write_reg(A_CTRL, 8'h40);
    check("R8 irq with enable and pending", irq, 1);
    read_reg(A_EVT, v);
    check("R8 irq drops after clear", irq, 0);
    write_reg(A_CTRL, 8'h00);
  endtask

  task automatic t_busy_write();
    logic [7:0] v;
    write_reg(A_TX, 8'h0F);
    write_reg(A_CTRL, 8'h10);
    write_reg(A_CTRL, 8'h40);
    peek(A_CTRL, v); check("R9 GO held, enable updated while busy", v, 8'h50);
    write_reg(A_CTRL, 8'h16);
    peek(A_CTRL, v); check("R9 INIT/DIR ignored while busy", v, 8'h10);
    wait_idle(8*CELL + 5);
    peek(A_CTRL, v); check("R9 busy write did not change operation", v, 8'h00);
    read_reg(A_EVT, v); check("R9 operation still a send", v, 8'h04);
  endtask

  task automatic t_rx(logic [7:0] b);
    logic [7:0] v;
    read_reg(A_EVT, v);
    oe_seen = 1'b0;
    write_reg(A_CTRL, 8'h12);
    slave_send(b, 3);
    wait_idle(CELL);
    peek(A_CTRL, v); check("R4 GO cleared, DIR kept", v, 8'h02);
    read_reg(A_EVT, v); check("R4 received flag", v, 8'h02);
    peek(A_RX, v); check("R4 received byte", v, b);
    check("R4 line not driven in receive", oe_seen, 0);
  endtask

  task automatic t_rx_timeout();
    logic [7:0] v;
    read_reg(A_EVT, v);
    write_reg(A_CTRL, 8'h12);
    for (int i = 0; i < RXW; i++) begin
      if (i == RXW-1) begin peek(A_CTRL, v); check("R5 GO held before window end", v[4], 1); end
      @(negedge clk);
    end
    peek(A_CTRL, v); check("R5 GO cleared at window end", v, 8'h02);
    read_reg(A_EVT, v); check("R5 timeout flag only", v, 8'h01);
  endtask

  task automatic t_break(logic [7:0] cmd);
    logic [7:0] v;
    int errs = 0;
    write_reg(A_CTRL, cmd);
    for (int i = 0; i < BLOW + BREC; i++) begin
      if (line_oe !== (i < BLOW)) errs++;
      if (i == BLOW + BREC - 1) begin peek(A_CTRL, v); check("R6 INIT+GO held", v & 8'h14, 8'h14); end
      @(negedge clk);
    end
    check("R6 break pulse shape", errs, 0);
    peek(A_CTRL, v); check("R6 INIT and GO cleared", v & 8'h14, 0);
    read_reg(A_EVT, v); check("R6 break ends with timeout flag", v, 8'h01);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    write_reg(A_TX, 8'h77);
    write_reg(A_CTRL, 8'h50);
    repeat (3) @(negedge clk);
    write_reg(A_CFG, 8'h03);
    check("R10 line released on soft reset", line_oe, 0);
    peek(A_CTRL, v); check("R10 ctrl cleared", v, 0);
    peek(A_TX, v);   check("R10 tx cleared", v, 0);
    peek(A_CFG, v);  check("R10 config cleared, reset bit reads 0", v, 0);
    peek(A_STAT, v); check("R10 reset-done low", v, 0);
    write_reg(A_TX, 8'h11);
    peek(A_STAT, v); check("R10 reset-done still low", v, 0);
    @(negedge clk);
    peek(A_STAT, v); check("R10 reset-done low in last cycle", v, 0);
    @(negedge clk);
    peek(A_STAT, v); check("R10 reset-done back after RST_CYC", v, 1);
    peek(A_TX, v);   check("R10 write during reset ignored", v, 0);
    peek(A_EVT, v);  check("R10 aborted send raises no flag", v, 0);
    write_reg(A_CFG, 8'h01);
    peek(A_CFG, v);  check("R10 auto-idle bit stored", v, 8'h01);
    write_reg(A_CFG, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_tx(8'h35);
    t_tx(8'hCA);
    t_irq();
    t_busy_write();
    t_rx(8'hC6);
    t_rx(8'h3A);
    t_rx_timeout();
    t_break(8'h14);
    t_break(8'h16);
    t_soft_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule